// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block works out the architectural state change that a small 32-bit processor makes when it enters an exception handler. Each cycle it looks at a synchronous exception request with its cause code, and at the external interrupt line. When an entry is taken, it produces the redirected fetch address and a write-back of the return address. It also updates the interrupt-enable register, which it owns. That register holds a global enable and two shadow copies: one for ordinary exceptions and one for debug exceptions.

The handler address is the selected vector base plus the cause number shifted left by five, which gives 32-byte handler slots. Breakpoint and watchpoint entries use the debug base and the debug return-address register. All other causes use the normal base and the exception return-address register. A remap control input moves those other causes onto the debug base as well. A system call that the host-call hook accepts does not vector at all. It only advances the PC by four. Software can load the enable register through a simple write port.

All results are registered. They appear on the outputs one clock after the request cycle.

Top module: `exc_entry_ctrl`

## Requirements
- R1: For every taken entry, `redir_pc` equals the selected base plus the cause code times 32. The normal base `norm_base` is used when `dbg_remap` is 0 and the cause is not a debug cause.
- R2: For an ordinary cause, the entry asserts `ra_we` with `ra_dbg`=0 and `ra_data` equal to the request-cycle `cur_pc`. Ordinary causes are: instruction bus error 2, data bus error 4, divide by zero 5, interrupt 6, and system call 7 without hook.
- R3: On an ordinary entry, bit 1 of `ie_q` (exception shadow) becomes its old value OR the old bit 0 (global enable). Bit 0 becomes 0, and bit 2 is unchanged.
- R4: A breakpoint (cause 1) or watchpoint (cause 3) asserts `ra_we` with `ra_dbg`=1 and `ra_data`=`cur_pc`. Bit 2 of `ie_q` (debug shadow) becomes its old value OR the old bit 0. Bit 0 is cleared, and bit 1 is unchanged.
- R5: Debug causes always vector from `dbg_base`. Ordinary causes vector from `dbg_base` when `dbg_remap` is 1.
- R6: When `exc_valid` is 0, an interrupt entry with cause 6 is taken only if `irq` is 1 and bit 0 of `ie_q` is 1. Otherwise no redirect happens and the state is unchanged.
- R7: A cause-7 request with `hook_ack`=1 gives `redir_vld` with `redir_pc`=`cur_pc`+4. It gives no `ra_we`, and `ie_q` is unchanged.
- R8: An entry never clears a shadow bit. When the global enable was 0, the shadow bit keeps its prior value.
- R9: A valid synchronous request takes priority over `irq` in the same cycle. The saved cause and vector are those of the synchronous request.
- R10: A request with cause 0 or any cause of 8 or above makes no redirect, no write-back and no change to `ie_q`. It sets `fatal_err`, which stays 1 until reset.
- R11: While reset is applied, and after it is released, `redir_vld`, `ra_we`, `fatal_err` and `ie_q` are 0.
- R12: With `ie_wr_en`=1 and no entry, `ie_q` loads `ie_wr_data`, where bit 0 is the global enable, bit 1 the exception shadow and bit 2 the debug shadow. If an entry is taken in the same cycle, the entry's update wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cur_pc | input | 32 | PC of the instruction taking the exception |
| exc_valid | input | 1 | Synchronous exception request |
| exc_cause | input | 4 | Cause code of the synchronous request |
| hook_ack | input | 1 | Host-call hook accepted the system call |
| irq | input | 1 | External interrupt request |
| norm_base | input | 32 | Normal vector base |
| dbg_base | input | 32 | Debug vector base |
| dbg_remap | input | 1 | Send ordinary causes to the debug base |
| ie_wr_en | input | 1 | Software write strobe for the enable register |
| ie_wr_data | input | 3 | Value written: {debug shadow, exception shadow, global enable} |
| redir_vld | output | 1 | Fetch redirect strobe |
| redir_pc | output | 32 | New fetch address |
| ra_we | output | 1 | Return-address write strobe |
| ra_dbg | output | 1 | 1: breakpoint-address register, 0: exception-address register |
| ra_data | output | 32 | Return address to write |
| ie_q | output | 3 | Enable register {debug shadow, exception shadow, global enable} |
| fatal_err | output | 1 | Sticky undefined-cause flag |

## Verification
Two situations can land in the same cycle: a synchronous request alongside a pending interrupt, and an entry alongside a software write to the enable register. The sweep drives every cause code with `irq` high and low, and with each starting enable value. It judges each outcome against the synchronous request's own vector, return address and enable update, and never against the interrupt's. A separate case raises the enable-register write in the same cycle as an ordinary entry. It then expects the entry's shadow update rather than the written value.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  // Cause codes; handler slot offset is the code times the slot size.
  localparam int unsigned CODE_BRK   = 1;
  localparam int unsigned CODE_IBUS  = 2;
  localparam int unsigned CODE_WATCH = 3;
  localparam int unsigned CODE_DBUS  = 4;
  localparam int unsigned CODE_DIV0  = 5;
  localparam int unsigned CODE_IRQ   = 6;
  localparam int unsigned CODE_SCALL = 7;

  // Enable register bit positions.
  localparam int unsigned IE_GIE = 0;
  localparam int unsigned IE_EIE = 1;
  localparam int unsigned IE_BIE = 2;
  localparam int unsigned IE_W   = 3;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_NORM = 3'd1,
    K_DBG  = 3'd2,
    K_HOOK = 3'd3,
    K_BAD  = 3'd4
  } entry_kind_e;

endpackage

// File: rtl/exc_cause_dec.sv
module exc_cause_dec
  import exc_entry_pkg::*;
#(
  parameter int unsigned CAUSE_W = 4
) (
  input  logic               exc_valid,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic               hook_ack,
  input  logic               irq,
  input  logic               gie,
  output entry_kind_e        kind,
  output logic [CAUSE_W-1:0] eff_cause
);

  localparam logic [CAUSE_W-1:0] C_BRK   = CAUSE_W'(CODE_BRK);
  localparam logic [CAUSE_W-1:0] C_IBUS  = CAUSE_W'(CODE_IBUS);
  localparam logic [CAUSE_W-1:0] C_WATCH = CAUSE_W'(CODE_WATCH);
  localparam logic [CAUSE_W-1:0] C_DBUS  = CAUSE_W'(CODE_DBUS);
  localparam logic [CAUSE_W-1:0] C_DIV0  = CAUSE_W'(CODE_DIV0);
  localparam logic [CAUSE_W-1:0] C_IRQ   = CAUSE_W'(CODE_IRQ);
  localparam logic [CAUSE_W-1:0] C_SCALL = CAUSE_W'(CODE_SCALL);

  always_comb begin
    kind      = K_NONE;
    eff_cause = exc_cause;
    if (exc_valid) begin
      // Synchronous request outranks the interrupt line.
      if (exc_cause == C_BRK || exc_cause == C_WATCH) begin
        kind = K_DBG;
      end else if (exc_cause == C_SCALL) begin
        kind = hook_ack ? K_HOOK : K_NORM;
      end else if (exc_cause == C_IBUS || exc_cause == C_DBUS ||
                   exc_cause == C_DIV0 || exc_cause == C_IRQ) begin
        kind = K_NORM;
      end else begin
        kind = K_BAD;
      end
    end else if (irq && gie) begin
      kind      = K_NORM;
      eff_cause = C_IRQ;
    end
  end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_entry_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned CAUSE_W    = 4,
  parameter int unsigned SLOT_SHIFT = 5
) (
  input  entry_kind_e        kind,
  input  logic [CAUSE_W-1:0] cause,
  input  logic               dbg_remap,
  input  logic [XLEN-1:0]    norm_base,
  input  logic [XLEN-1:0]    dbg_base,
  input  logic [XLEN-1:0]    cur_pc,
  output logic [XLEN-1:0]    tgt_pc
);

  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

  logic [XLEN-1:0] base_sel;
  logic [XLEN-1:0] slot_off;

  always_comb begin
    base_sel = (kind == K_DBG || dbg_remap) ? dbg_base : norm_base;
    slot_off = XLEN'(cause) << SLOT_SHIFT;
    if (kind == K_HOOK) begin
      tgt_pc = cur_pc + PC_STEP;
    end else begin
      tgt_pc = base_sel + slot_off;
    end
  end

endmodule

// File: rtl/exc_ie_reg.sv
module exc_ie_reg
  import exc_entry_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  entry_kind_e     kind,
  input  logic            wr_en,
  input  logic [IE_W-1:0] wr_data,
  output logic [IE_W-1:0] ie_q
);

  logic [IE_W-1:0] ie_d;
  logic            ie_en;

  always_comb begin
    ie_d  = ie_q;
    ie_en = 1'b0;
    unique case (kind)
      K_NORM: begin
        ie_en          = 1'b1;
        ie_d[IE_EIE]   = ie_q[IE_EIE] | ie_q[IE_GIE];
        ie_d[IE_GIE]   = 1'b0;
      end
      K_DBG: begin
        ie_en          = 1'b1;
        ie_d[IE_BIE]   = ie_q[IE_BIE] | ie_q[IE_GIE];
        ie_d[IE_GIE]   = 1'b0;
      end
      K_HOOK: begin
        ie_en = 1'b0;
      end
      default: begin
        if (wr_en && kind == K_NONE) begin
          ie_en = 1'b1;
          ie_d  = wr_data;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= '0;
    end else if (ie_en) begin
      ie_q <= ie_d;
    end
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned CAUSE_W    = 4,
  parameter int unsigned SLOT_SHIFT = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic               exc_valid,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic               hook_ack,
  input  logic               irq,
  input  logic [XLEN-1:0]    norm_base,
  input  logic [XLEN-1:0]    dbg_base,
  input  logic               dbg_remap,
  input  logic               ie_wr_en,
  input  logic [2:0]         ie_wr_data,
  output logic               redir_vld,
  output logic [XLEN-1:0]    redir_pc,
  output logic               ra_we,
  output logic               ra_dbg,
  output logic [XLEN-1:0]    ra_data,
  output logic [2:0]         ie_q,
  output logic               fatal_err
);

  // Reset release synchronizer.
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  entry_kind_e        kind;
  logic [CAUSE_W-1:0] eff_cause;
  logic [XLEN-1:0]    tgt_pc;

  exc_cause_dec #(.CAUSE_W(CAUSE_W)) u_dec (
    .exc_valid (exc_valid),
    .exc_cause (exc_cause),
    .hook_ack  (hook_ack),
    .irq       (irq),
    .gie       (ie_q[IE_GIE]),
    .kind      (kind),
    .eff_cause (eff_cause)
  );

  exc_vector_gen #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .SLOT_SHIFT(SLOT_SHIFT)
  ) u_vec (
    .kind      (kind),
    .cause     (eff_cause),
    .dbg_remap (dbg_remap),
    .norm_base (norm_base),
    .dbg_base  (dbg_base),
    .cur_pc    (cur_pc),
    .tgt_pc    (tgt_pc)
  );

  exc_ie_reg u_ie (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .kind    (kind),
    .wr_en   (ie_wr_en),
    .wr_data (ie_wr_data),
    .ie_q    (ie_q)
  );

  // Next-state logic for the registered outputs.
  logic redir_vld_d, ra_we_d, ra_dbg_d, fatal_d;
  logic take_en;

  always_comb begin
    take_en     = (kind == K_NORM) || (kind == K_DBG) || (kind == K_HOOK);
    redir_vld_d = take_en;
    ra_we_d     = (kind == K_NORM) || (kind == K_DBG);
    ra_dbg_d    = (kind == K_DBG);
    fatal_d     = fatal_err | (kind == K_BAD);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      redir_vld <= 1'b0;
      ra_we     <= 1'b0;
      fatal_err <= 1'b0;
    end else begin
      redir_vld <= redir_vld_d;
      ra_we     <= ra_we_d;
      fatal_err <= fatal_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      redir_pc <= '0;
    end else if (take_en) begin
      redir_pc <= tgt_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ra_dbg  <= 1'b0;
      ra_data <= '0;
    end else if (ra_we_d) begin
      ra_dbg  <= ra_dbg_d;
      ra_data <= cur_pc;
    end
  end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 4
) (
  input logic               clk,
  input logic               rst_act_n,
  input logic [XLEN-1:0]    cur_pc,
  input logic               exc_valid,
  input logic [CAUSE_W-1:0] exc_cause,
  input logic               irq,
  input logic               redir_vld,
  input logic [XLEN-1:0]    redir_pc,
  input logic               ra_we,
  input logic               ra_dbg,
  input logic [XLEN-1:0]    ra_data,
  input logic [2:0]         ie_q,
  input logic               fatal_err
);

  a_r2_ra_with_redirect: assert property (@(posedge clk) disable iff (!rst_act_n)
    ra_we |-> redir_vld);

  a_r2_ra_data_is_pc: assert property (@(posedge clk) disable iff (!rst_act_n)
    ra_we |-> ra_data == $past(cur_pc));

  a_r3_gie_cleared: assert property (@(posedge clk) disable iff (!rst_act_n)
    ra_we |-> !ie_q[0]);

  a_r4_eie_kept_on_debug: assert property (@(posedge clk) disable iff (!rst_act_n)
    (ra_we && ra_dbg) |-> ie_q[1] == $past(ie_q[1]));

  a_r8_eie_not_cleared: assert property (@(posedge clk) disable iff (!rst_act_n)
    (ra_we && !ra_dbg) |-> (!$past(ie_q[1]) || ie_q[1]));

  a_r8_bie_not_cleared: assert property (@(posedge clk) disable iff (!rst_act_n)
    (ra_we && ra_dbg) |-> (!$past(ie_q[2]) || ie_q[2]));

  a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_act_n)
    (ra_we && !$past(exc_valid)) |-> ($past(irq) && $past(ie_q[0])));

  a_r7_hook_step: assert property (@(posedge clk) disable iff (!rst_act_n)
    (redir_vld && !ra_we) |-> (redir_pc == $past(cur_pc) + XLEN'(4) && $stable(ie_q)));

  a_r10_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_act_n)
    fatal_err |=> fatal_err);

  a_r10_bad_cause: assert property (@(posedge clk) disable iff (!rst_act_n)
    ($past(exc_valid) && ($past(exc_cause) == '0 || $past(exc_cause) > CAUSE_W'(7)))
      |-> (!redir_vld && fatal_err));

endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (
  .clk       (clk),
  .rst_act_n (rst_sync_n),
  .cur_pc    (cur_pc),
  .exc_valid (exc_valid),
  .exc_cause (exc_cause),
  .irq       (irq),
  .redir_vld (redir_vld),
  .redir_pc  (redir_pc),
  .ra_we     (ra_we),
  .ra_dbg    (ra_dbg),
  .ra_data   (ra_data),
  .ie_q      (ie_q),
  .fatal_err (fatal_err)
);

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb;

  localparam logic [31:0] NBASE = 32'h0000_4000;
  localparam logic [31:0] DBASE = 32'hFFFF_F800;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cur_pc;
  logic        exc_valid;
  logic [3:0]  exc_cause;
  logic        hook_ack;
  logic        irq;
  logic [31:0] norm_base;
  logic [31:0] dbg_base;
  logic        dbg_remap;
  logic        ie_wr_en;
  logic [2:0]  ie_wr_data;
  logic        redir_vld;
  logic [31:0] redir_pc;
  logic        ra_we;
  logic        ra_dbg;
  logic [31:0] ra_data;
  logic [2:0]  ie_q;
  logic        fatal_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .exc_valid(exc_valid),
    .exc_cause(exc_cause), .hook_ack(hook_ack), .irq(irq),
    .norm_base(norm_base), .dbg_base(dbg_base), .dbg_remap(dbg_remap),
    .ie_wr_en(ie_wr_en), .ie_wr_data(ie_wr_data), .redir_vld(redir_vld),
    .redir_pc(redir_pc), .ra_we(ra_we), .ra_dbg(ra_dbg), .ra_data(ra_data),
    .ie_q(ie_q), .fatal_err(fatal_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    exc_valid  = 1'b0;
    exc_cause  = '0;
    hook_ack   = 1'b0;
    irq        = 1'b0;
    ie_wr_en   = 1'b0;
    ie_wr_data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_case(input bit ev, input int cause, input bit rq, input bit hk,
                          input bit rm, input logic [2:0] ie0, input logic [31:0] pc);
    bit          bad, dbg, hook, norm;
    logic [3:0]  c_eff;
    logic [31:0] exp_pc;
    logic [2:0]  exp_ie;
    do_reset();
    ie_wr_en   = 1'b1;
    ie_wr_data = ie0;
    @(negedge clk);
    ie_wr_en = 1'b0;
    check("R12 load", {29'd0, ie_q}, {29'd0, ie0});
    exc_valid = ev;
    exc_cause = cause[3:0];
    irq       = rq;
    hook_ack  = hk;
    dbg_remap = rm;
    cur_pc    = pc;
    @(negedge clk);
    idle_inputs();
    bad  = ev && (cause == 0 || cause > 7);
    dbg  = ev && (cause == 1 || cause == 3);
    hook = ev && cause == 7 && hk;
    norm = (ev && !bad && !dbg && !hook) || (!ev && rq && ie0[0]);
    c_eff  = ev ? cause[3:0] : 4'd6;
    exp_ie = ie0;
    if (norm) exp_ie = {ie0[2], ie0[1] | ie0[0], 1'b0};
    if (dbg)  exp_ie = {ie0[2] | ie0[0], ie0[1], 1'b0};
    if (hook) exp_pc = pc + 32'd4;
    else      exp_pc = ((dbg || rm) ? DBASE : NBASE) + {23'd0, c_eff, 5'd0};
    check(ev ? "R9 R10 redirect" : "R6 redirect", {31'd0, redir_vld}, {31'd0, norm | dbg | hook});
    check("R2 R4 R7 ra_we", {31'd0, ra_we}, {31'd0, norm | dbg});
    check("R3 R4 R8 ie", {29'd0, ie_q}, {29'd0, exp_ie});
    check("R10 fatal", {31'd0, fatal_err}, {31'd0, bad});
    if (norm | dbg | hook) check(hook ? "R7 pc" : "R1 R5 pc", redir_pc, exp_pc);
    if (norm | dbg) begin
      check("R2 R4 ra_dbg", {31'd0, ra_dbg}, {31'd0, dbg});
      check("R2 R4 ra_data", ra_data, pc);
    end
    if (bad) begin
      @(negedge clk);
      check("R10 fatal sticky", {31'd0, fatal_err}, 32'd1);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    cur_pc    = '0;
    dbg_remap = 1'b0;
    norm_base = NBASE;
    dbg_base  = DBASE;
    repeat (2) @(negedge clk);
    check("R11 redir_vld", {31'd0, redir_vld}, 32'd0);
    check("R11 ra_we", {31'd0, ra_we}, 32'd0);
    check("R11 ie", {29'd0, ie_q}, 32'd0);
    check("R11 fatal", {31'd0, fatal_err}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 after release", {28'd0, redir_vld, ra_we, fatal_err, |ie_q}, 32'd0);

    for (int ev = 0; ev < 2; ev++)
      for (int cs = 0; cs < 16; cs++)
        for (int rq = 0; rq < 2; rq++)
          for (int hk = 0; hk < 2; hk++)
            for (int rm = 0; rm < 2; rm++)
              for (int ie = 0; ie < 8; ie++)
                run_case(ev[0], cs, rq[0], hk[0], rm[0], ie[2:0],
                         32'h1000_0000 + 32'(((cs * 8) + ie) * 4));

    // R12: a write in the same cycle as an ordinary entry is dropped.
    do_reset();
    ie_wr_en = 1'b1; ie_wr_data = 3'b001;
    @(negedge clk);
    ie_wr_data = 3'b110;
    exc_valid = 1'b1; exc_cause = 4'd2; dbg_remap = 1'b0; cur_pc = 32'h0000_0100;
    @(negedge clk);
    idle_inputs();
    check("R12 entry wins", {29'd0, ie_q}, 32'd2);
    check("R1 bus error slot", redir_pc, NBASE + 32'd64);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule